// File: doc/BRIEF.md
# Shared Reset / Non-Maskable Interrupt Pin Controller

This block owns a single active-low external pin that serves one of two jobs. In reset mode the pin works as a level-sensitive system reset. In interrupt mode it becomes an edge-triggered source of a non-maskable interrupt, and a configuration bit chooses the active edge. The block produces the chip-wide power-up clear (`puc`). It keeps a pending-interrupt flag that is cleared when the interrupt logic acknowledges it. It also keeps a flag that records whether the most recent reset came from the watchdog or from a protected write, rather than from the pin or from power-on.

Configuration is written as 16-bit words. The low byte is the control byte. The high byte must carry a fixed key. A write with any other key is treated as a security violation: the control byte keeps its value and a clear is issued. Every clear returns the control byte to zero, which puts the pin back into reset mode. The raw pin is resynchronised before use. Edge detection compares the synchronised level, XOR-ed with the edge-select bit, against its value in the previous cycle. Because of this, changing the edge select while interrupt mode is already active can itself raise an interrupt.

Top module: `rstnmi_pin_ctrl`

## Requirements
- R1: With control bit 0 (mode) clear, a low level on `pin_n` asserts `puc`. The assertion appears on the third rising clock edge after the pin change (two synchronizer stages plus one register), and `puc` stays high as long as the pin stays low.
- R2: After its last cause goes away, `puc` stays high for exactly `PUC_HOLD` (default 2) more clock edges and then drops.
- R3: While `por` is high, `puc` is high. After `por` is released, the control byte, the interrupt flag and the reset-source flag all read 0.
- R4: A write whose bits [15:8] equal `KEY_VALUE` (default 0x5A) loads bits [7:0] into `ctrl_q` on the next edge. Bit 0 selects interrupt mode and bit 1 selects falling-edge triggering. Such a write causes no `puc`.
- R5: A write with any other key leaves `ctrl_q` unchanged, asserts `puc` on the next edge and sets `rsrc_flag`.
- R6: A `wdt_ovf` pulse asserts `puc` and sets `rsrc_flag` on the next edge.
- R7: A reset caused by the pin clears `rsrc_flag` on the same edge that asserts `puc`.
- R8: Any `puc` clears `ctrl_q` to 0, which returns the pin to reset mode.
- R9: In interrupt mode a low pin causes no `puc`. With bit 1 clear, only a rising pin edge sets `nmi_pend`, three edges after the pin change. With bit 1 set, only a falling edge does.
- R10: `nmi_pend` stays set until `irq_ack` is high at a clock edge, which clears it on that edge. `puc` also clears it.
- R11: In interrupt mode, a write that changes bit 1 sets `nmi_pend` two edges after the write is driven if the change makes the polarity-adjusted level rise: 0→1 with the pin low, or 1→0 with the pin high. The opposite changes set nothing, and changing bit 1 while in reset mode sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| pin_n | input | 1 | Raw level of the shared active-low pin |
| wdt_ovf | input | 1 | Watchdog overflow in watchdog mode, one-cycle pulse |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 16 | Write word: key in [15:8], control byte in [7:0] |
| irq_ack | input | 1 | Interrupt logic accepted the pin interrupt |
| puc | output | 1 | Power-up clear to the rest of the chip |
| nmi_pend | output | 1 | Pin interrupt flag, also the request to the interrupt logic |
| ctrl_q | output | 8 | Current control byte (bit 0 mode, bit 1 edge select) |
| rsrc_flag | output | 1 | Last reset came from the watchdog or a key violation |

## Verification
A control byte that fails to clear shows up at once on `ctrl_q` in the cycle after a clear. It then leaves the pin in interrupt mode, so a later low level wrongly produces no `puc` within three edges. An edge detector that tracks the wrong polarity, or that loses its previous sample, shows as `nmi_pend` rising one cycle too early, on the wrong pin transition, or on an edge-select write that should be silent. A hold counter that is off by one shows as `puc` falling one edge early or late after the pin is released or a violation occurs.

// File: rtl/rstnmi_pkg.sv
package rstnmi_pkg;
  localparam int MODE_BIT = 0;
  localparam int EDGE_BIT = 1;

  typedef struct packed {
    logic [7:0] key;
    logic [7:0] ctrl;
  } wr_word_t;
endpackage

// File: rtl/rstnmi_sync.sv
module rstnmi_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rstnmi_cfg_reg.sv
module rstnmi_cfg_reg
  import rstnmi_pkg::*;
#(
  parameter logic [7:0] KEY_VALUE = 8'h5A
) (
  input  logic        clk,
  input  logic        clr,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [7:0]  ctrl_q,
  output logic        key_bad
);
  wr_word_t word;
  logic     key_ok;

  assign word    = wr_word_t'(wr_data);
  assign key_ok  = (word.key == KEY_VALUE);
  assign key_bad = wr_en && !key_ok;

  always_ff @(posedge clk) begin
    if (clr)                  ctrl_q <= '0;
    else if (wr_en && key_ok) ctrl_q <= word.ctrl;
  end
endmodule

// File: rtl/rstnmi_edge_det.sv
module rstnmi_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic fall_sel,
  input  logic nmi_mode,
  output logic trig
);
  logic eff_now, eff_prev, mode_d;

  // polarity-adjusted level: an edge-select change looks like a pin edge
  assign eff_now = lvl ^ fall_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_prev <= 1'b1;
      mode_d   <= 1'b0;
    end else begin
      eff_prev <= eff_now;
      mode_d   <= nmi_mode;
    end
  end

  assign trig = nmi_mode && mode_d && eff_now && !eff_prev;
endmodule

// File: rtl/rstnmi_puc_stretch.sv
module rstnmi_puc_stretch #(
  parameter int PUC_HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cause,
  output logic puc
);
  localparam int CW = $clog2(PUC_HOLD + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || cause)   cnt <= CW'(PUC_HOLD);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign puc = (cnt != '0);
endmodule

// File: rtl/rstnmi_pin_ctrl.sv
module rstnmi_pin_ctrl
  import rstnmi_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         PUC_HOLD    = 2,
  parameter logic [7:0] KEY_VALUE   = 8'h5A
) (
  input  logic        clk,
  input  logic        por,
  input  logic        pin_n,
  input  logic        wdt_ovf,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        irq_ack,
  output logic        puc,
  output logic        nmi_pend,
  output logic [7:0]  ctrl_q,
  output logic        rsrc_flag
);
  logic pin_lvl, key_bad, trig, pin_rst, puc_cause;

  rstnmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(por), .d(pin_n), .q(pin_lvl)
  );

  rstnmi_cfg_reg #(.KEY_VALUE(KEY_VALUE)) u_cfg (
    .clk(clk), .clr(por || puc), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .key_bad(key_bad)
  );

  rstnmi_edge_det u_edge (
    .clk(clk), .rst(por), .lvl(pin_lvl), .fall_sel(ctrl_q[EDGE_BIT]),
    .nmi_mode(ctrl_q[MODE_BIT]), .trig(trig)
  );

  assign pin_rst   = !ctrl_q[MODE_BIT] && !pin_lvl;
  assign puc_cause = por || pin_rst || wdt_ovf || key_bad;

  rstnmi_puc_stretch #(.PUC_HOLD(PUC_HOLD)) u_puc (
    .clk(clk), .rst(por), .cause(puc_cause), .puc(puc)
  );

  always_ff @(posedge clk) begin
    if (por || puc) nmi_pend <= 1'b0;
    else if (trig)  nmi_pend <= 1'b1;
    else if (irq_ack) nmi_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (por)                     rsrc_flag <= 1'b0;
    else if (wdt_ovf || key_bad) rsrc_flag <= 1'b1;
    else if (pin_rst)            rsrc_flag <= 1'b0;
  end
endmodule

// File: rtl/rstnmi_pin_ctrl_chk.sv
module rstnmi_pin_ctrl_chk #(
  parameter logic [7:0] KEY_VALUE = 8'h5A
) (
  input logic        clk,
  input logic        por,
  input logic        wdt_ovf,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic        irq_ack,
  input logic        puc,
  input logic        nmi_pend,
  input logic [7:0]  ctrl_q,
  input logic        rsrc_flag,
  input logic        pin_lvl,
  input logic        puc_cause
);
  AST_PIN_LOW_CLEARS: assert property (@(posedge clk) disable iff (por)
    (!ctrl_q[0] && !pin_lvl) |=> puc); // R1
  AST_PUC_STRETCH: assert property (@(posedge clk) disable iff (por)
    $fell(puc) |-> (!$past(puc_cause) && !$past(puc_cause, 2))); // R2
  AST_GOOD_KEY_LOADS: assert property (@(posedge clk) disable iff (por)
    (wr_en && wr_data[15:8] == KEY_VALUE && !puc) |=> (ctrl_q == $past(wr_data[7:0]))); // R4
  AST_BAD_KEY_CLEARS: assert property (@(posedge clk) disable iff (por)
    (wr_en && wr_data[15:8] != KEY_VALUE && !puc) |=> (puc && rsrc_flag && $stable(ctrl_q))); // R5
  AST_WDT_CLEARS: assert property (@(posedge clk) disable iff (por)
    wdt_ovf |=> (puc && rsrc_flag)); // R6
  AST_PUC_ZEROES_CTRL: assert property (@(posedge clk) disable iff (por)
    puc |=> (ctrl_q[1:0] == 2'b00)); // R8
  AST_NMI_MODE_NO_PIN_RESET: assert property (@(posedge clk) disable iff (por)
    (ctrl_q[0] && !puc && !wdt_ovf && !wr_en) |=> !puc); // R9
  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (por)
    (nmi_pend && !irq_ack && !puc) |=> nmi_pend); // R10
endmodule

bind rstnmi_pin_ctrl rstnmi_pin_ctrl_chk #(.KEY_VALUE(KEY_VALUE)) chk_i (
  .clk(clk), .por(por), .wdt_ovf(wdt_ovf), .wr_en(wr_en), .wr_data(wr_data),
  .irq_ack(irq_ack), .puc(puc), .nmi_pend(nmi_pend), .ctrl_q(ctrl_q),
  .rsrc_flag(rsrc_flag), .pin_lvl(pin_lvl), .puc_cause(puc_cause)
);

// File: tb/rstnmi_pin_ctrl_tb_top.sv
`timescale 1ns/1ps
module rstnmi_pin_ctrl_tb_top;
  localparam int S_PUC = 0, S_NMI = 1, S_MODE = 2, S_EDGE = 3, S_RSRC = 4;

  logic clk = 1'b0;
  logic por = 1'b1, pin_n = 1'b1, wdt_ovf = 1'b0, wr_en = 1'b0, irq_ack = 1'b0;
  logic [15:0] wr_data = '0;
  logic puc, nmi_pend, rsrc_flag;
  logic [7:0] ctrl_q;

  int cyc = 0, checks = 0, errors = 0;
  bit finished = 0;

  typedef struct {
    int    cyc;
    int    sig;
    logic  val;
    string req;
  } item_t;
  item_t exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rstnmi_pin_ctrl dut_i (
    .clk(clk), .por(por), .pin_n(pin_n), .wdt_ovf(wdt_ovf), .wr_en(wr_en),
    .wr_data(wr_data), .irq_ack(irq_ack), .puc(puc), .nmi_pend(nmi_pend),
    .ctrl_q(ctrl_q), .rsrc_flag(rsrc_flag)
  );

  function automatic logic sample(int s);
    case (s)
      S_PUC:   return puc;
      S_NMI:   return nmi_pend;
      S_MODE:  return ctrl_q[0];
      S_EDGE:  return ctrl_q[1];
      default: return rsrc_flag;
    endcase
  endfunction

  // driver side: schedule an expected value d clock edges from now
  task automatic expect_v(int d, int s, logic v, string r);
    item_t it;
    int i;
    it.cyc = cyc + d; it.sig = s; it.val = v; it.req = r;
    i = exp_q.size();
    while (i > 0 && exp_q[i-1].cyc > it.cyc) i--;
    exp_q.insert(i, it);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_word(logic [15:0] w);
    wr_en = 1'b1; wr_data = w;
    tick(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1;
    expect_v(1, S_NMI, 1'b0, "R10");
    tick(1);
    irq_ack = 1'b0;
    tick(2);
  endtask

  // monitor side: pop due items and compare at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
      item_t it;
      logic act;
      it = exp_q.pop_front();
      act = sample(it.sig);
      checks++;
      if (act !== it.val) begin
        errors++;
        $display("FAIL %s signal %0d at cycle %0d: actual %b expected %b",
                 it.req, it.sig, cyc, act, it.val);
      end
    end
  end

  initial begin
    tick(3);
    por = 1'b0;
    expect_v(1, S_PUC, 1'b1, "R3");
    expect_v(2, S_PUC, 1'b0, "R2");
    expect_v(2, S_MODE, 1'b0, "R3");
    expect_v(2, S_EDGE, 1'b0, "R3");
    expect_v(2, S_NMI, 1'b0, "R3");
    expect_v(2, S_RSRC, 1'b0, "R3");
    tick(4);

    // watchdog overflow
    wdt_ovf = 1'b1;
    expect_v(1, S_PUC, 1'b1, "R6");
    expect_v(1, S_RSRC, 1'b1, "R6");
    tick(1);
    wdt_ovf = 1'b0;
    expect_v(2, S_PUC, 1'b0, "R2");
    tick(4);

    // pin reset in reset mode, level sensitive
    pin_n = 1'b0;
    expect_v(2, S_PUC, 1'b0, "R1");
    expect_v(2, S_RSRC, 1'b1, "R7");
    expect_v(3, S_PUC, 1'b1, "R1");
    expect_v(3, S_RSRC, 1'b0, "R7");
    expect_v(8, S_PUC, 1'b1, "R1");
    tick(8);
    pin_n = 1'b1;
    expect_v(3, S_PUC, 1'b1, "R2");
    expect_v(4, S_PUC, 1'b0, "R2");
    tick(6);

    // wrong key
    expect_v(1, S_PUC, 1'b1, "R5");
    expect_v(1, S_RSRC, 1'b1, "R5");
    expect_v(1, S_MODE, 1'b0, "R5");
    expect_v(1, S_EDGE, 1'b0, "R5");
    expect_v(2, S_PUC, 1'b1, "R2");
    expect_v(3, S_PUC, 1'b0, "R2");
    write_word(16'h1203);
    tick(4);

    // correct key: interrupt mode, rising edge
    expect_v(1, S_MODE, 1'b1, "R4");
    expect_v(1, S_EDGE, 1'b0, "R4");
    expect_v(1, S_PUC, 1'b0, "R4");
    expect_v(1, S_RSRC, 1'b1, "R4");
    write_word(16'h5A01);
    tick(3);

    // low pin in interrupt mode: no clear, falling edge ignored
    pin_n = 1'b0;
    expect_v(3, S_PUC, 1'b0, "R9");
    expect_v(6, S_PUC, 1'b0, "R9");
    expect_v(6, S_NMI, 1'b0, "R9");
    tick(8);
    pin_n = 1'b1;
    expect_v(2, S_NMI, 1'b0, "R9");
    expect_v(3, S_NMI, 1'b1, "R9");
    expect_v(6, S_NMI, 1'b1, "R10");
    tick(6);
    ack_pulse();

    // edge select 0->1 with pin low raises an interrupt
    pin_n = 1'b0;
    tick(5);
    expect_v(1, S_NMI, 1'b0, "R11");
    expect_v(2, S_NMI, 1'b1, "R11");
    write_word(16'h5A03);
    tick(3);
    ack_pulse();

    // falling-edge select: rising ignored, falling triggers
    pin_n = 1'b1;
    expect_v(4, S_NMI, 1'b0, "R9");
    tick(5);
    pin_n = 1'b0;
    expect_v(2, S_NMI, 1'b0, "R9");
    expect_v(3, S_NMI, 1'b1, "R9");
    tick(5);
    ack_pulse();

    // edge select 1->0 with pin high raises an interrupt, 0->1 does not
    pin_n = 1'b1;
    tick(5);
    expect_v(2, S_NMI, 1'b1, "R11");
    write_word(16'h5A01);
    tick(3);
    ack_pulse();
    expect_v(2, S_NMI, 1'b0, "R11");
    expect_v(4, S_NMI, 1'b0, "R11");
    write_word(16'h5A03);
    tick(5);

    // pending interrupt, then a clear wipes flag and control byte
    pin_n = 1'b0;
    expect_v(3, S_NMI, 1'b1, "R9");
    tick(5);
    pin_n = 1'b1;
    tick(5);
    wdt_ovf = 1'b1;
    expect_v(1, S_PUC, 1'b1, "R6");
    expect_v(2, S_NMI, 1'b0, "R10");
    expect_v(2, S_MODE, 1'b0, "R8");
    expect_v(2, S_EDGE, 1'b0, "R8");
    tick(1);
    wdt_ovf = 1'b0;
    tick(4);

    // edge select changes while in reset mode: no interrupt
    expect_v(1, S_EDGE, 1'b1, "R11");
    expect_v(2, S_NMI, 1'b0, "R11");
    write_word(16'h5A02);
    tick(2);
    expect_v(2, S_NMI, 1'b0, "R11");
    expect_v(3, S_NMI, 1'b0, "R11");
    expect_v(3, S_PUC, 1'b0, "R11");
    write_word(16'h5A00);
    tick(4);

    while (exp_q.size() > 0) tick(1);
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule